// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This peripheral holds four independent timer channels behind a small synchronous register bus. Each channel has a 64-bit down-counter, a 64-bit interval register and a control word. The control word enables the channel, loads the interval into the counter, picks a power-of-two clock divider and selects periodic or one-shot behaviour. When a channel expires it raises its bit in a shared status register. Software clears that bit by writing a one to it. A shared enable mask decides which status bits drive the single interrupt line.

The host writes by presenting an address, write data and a one-cycle write strobe; the write takes effect at that clock edge. Reads are combinational from the address. A free-running channel loaded with all ones can serve as a time base: software reads the count and inverts it to get a value that rises. Another channel can act as an event source that fires once or repeatedly.

Each channel is controlled by a three-state machine. CH_IDLE holds the count while the channel is disabled. CH_RUN counts. CH_SPENT holds the counter at zero after a one-shot expiry. The transitions are as follows:
- IDLE→RUN: a control write with enable set.
- RUN→IDLE: a control write with enable clear.
- RUN→SPENT: an expiry in one-shot mode.
- SPENT→RUN: a control write with both enable and reload set.
- SPENT→IDLE: a control write with enable clear.

A control write with enable set while in RUN stays in RUN. A control write with enable set but reload clear while in SPENT stays in SPENT.

Top module: `evtimer_top`

## Requirements
- R1: After reset every register reads zero, every counter holds zero and irq_o is low.
- R2: The address map is as follows:
  - Interrupt enable is at 0x00 and interrupt status is at 0x04, with bit n belonging to channel n.
  - Channel n occupies 0x20*n+0x10. Its control word is at +0x00, its interval low word at +0x04, its interval high word at +0x08, its count low word at +0x0C and its count high word at +0x10.
  - Unmapped or unaligned addresses read zero.
  - Writes to the count words leave the counter unchanged.
- R3: The control word fields are as follows: bit 0 is enable, bit 1 is reload, bits 6:4 are the divider select and bit 7 selects one-shot (1) or periodic (0). Reload always reads back as 0, as do all bits outside these fields.
- R4: A control write with reload set copies the full 64-bit interval into the counter, visible from the next cycle, whether or not enable is set.
- R5: In CH_RUN with divider 0 the counter decreases by one each cycle. The cycle of a control write to the channel never counts.
- R6: With divider p the counter advances once every 2^p cycles. The divider phase restarts on any control write that sets enable or reload, so the first decrement lands 2^p cycles after that write.
- R7: An advance taken while the counter is zero is an expiry and sets the channel's status bit in the same edge.
- R8: In periodic mode an expiry reloads the interval and counting continues, so an interval I gives expiries every (I+1)*2^p cycles.
- R9: In one-shot mode an expiry leaves the counter at zero and the channel in CH_SPENT. No further expiry occurs until a reload.
- R10: A control write that clears enable freezes the counter at the value it holds at that edge.
- R11: Writing a 1 to a status bit clears it, and writing a 0 has no effect. An expiry in the same cycle as a clear leaves the bit set.
- R12: irq_o is high when any channel has its status bit and its enable bit both set. A clear enable bit masks the line but not the status bit.
- R13: A running channel loaded with all ones, with divider 0, reads as a bitwise-inverted count that rises by one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can meet in a single cycle: a channel's expiry sets its status bit, while a host write of one clears that same bit. The bench arms a periodic channel with a short interval and counts the cycles to its first expiry. It then times the clearing write so that the write's edge is exactly the expiry edge. The status bit is judged correct only if it reads back set afterwards. A later, uncontested clear must then read back as zero, which shows the clear path works when nothing competes with it.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_SPENT = 2'd2
    } ch_state_e;

    // control word field positions
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RLD_BIT = 1;
    localparam int CTRL_PRE_LSB = 4;
    localparam int CTRL_OS_BIT  = 7;

    // shared register offsets
    localparam int OFF_IEN   = 'h00;
    localparam int OFF_IST   = 'h04;
    localparam int CH_BASE   = 'h10;
    localparam int CH_SHIFT  = 5;

    // per-channel word offsets inside one stride
    localparam logic [4:0] SUB_CTRL   = 5'h00;
    localparam logic [4:0] SUB_IVL_LO = 5'h04;
    localparam logic [4:0] SUB_IVL_HI = 5'h08;
    localparam logic [4:0] SUB_CNT_LO = 5'h0C;
    localparam logic [4:0] SUB_CNT_HI = 5'h10;

endpackage

// File: rtl/evtimer_prescale.sv
module evtimer_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [PRE_W-1:0] sel,
    output logic             tick
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] mask;

    // low sel bits all ones; sel at its maximum wraps to an all-ones mask
    assign mask = (DIV_W'(1) << sel) - DIV_W'(1);
    assign tick = run && ((phase_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n)   phase_q <= '0;
        else if (clr) phase_q <= '0;
        else if (run) phase_q <= phase_q + DIV_W'(1);
    end
endmodule

// File: rtl/evtimer_channel.sv
module evtimer_channel
    import evtimer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_ctrl,
    input  logic                wr_ivl_lo,
    input  logic                wr_ivl_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   ctrl_o,
    output logic [2*DATA_W-1:0] ivl_o,
    output logic [2*DATA_W-1:0] cnt_o,
    output logic                en_o,
    output logic                expire_o
);
    localparam int CNT_W = 2 * DATA_W;

    ch_state_e        state_q, state_d;
    logic             en_q, os_q;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] ivl_q, cnt_q;

    logic             w_en, w_rld, w_os;
    logic [PRE_W-1:0] w_pre;
    logic             run, tick, expire, phase_clr;

    assign w_en  = wdata[CTRL_EN_BIT];
    assign w_rld = wdata[CTRL_RLD_BIT];
    assign w_os  = wdata[CTRL_OS_BIT];
    assign w_pre = wdata[CTRL_PRE_LSB +: PRE_W];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (wr_ctrl && w_en) state_d = CH_RUN;
            end
            CH_RUN: begin
                if (wr_ctrl)              state_d = w_en ? CH_RUN : CH_IDLE;
                else if (expire && os_q)  state_d = CH_SPENT;
            end
            CH_SPENT: begin
                if (wr_ctrl && !w_en)        state_d = CH_IDLE;
                else if (wr_ctrl && w_rld)   state_d = CH_RUN;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // state-dependent outputs
    always_comb begin
        run       = (state_q == CH_RUN) && !wr_ctrl;
        phase_clr = wr_ctrl && (w_en || w_rld);
        expire    = tick && (cnt_q == '0);
    end

    evtimer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (phase_clr),
        .run  (run),
        .sel  (pre_q),
        .tick (tick)
    );

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            os_q  <= 1'b0;
            pre_q <= '0;
            ivl_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= w_en;
                os_q  <= w_os;
                pre_q <= w_pre;
            end
            if (wr_ivl_lo) ivl_q[DATA_W-1:0]     <= wdata;
            if (wr_ivl_hi) ivl_q[CNT_W-1:DATA_W] <= wdata;
            if (wr_ctrl && w_rld) cnt_q <= ivl_q;
            else if (expire)      cnt_q <= os_q ? cnt_q : ivl_q;
            else if (tick)        cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        ctrl_o                        = '0;
        ctrl_o[CTRL_EN_BIT]           = en_q;
        ctrl_o[CTRL_PRE_LSB +: PRE_W] = pre_q;
        ctrl_o[CTRL_OS_BIT]           = os_q;
    end

    assign ivl_o    = ivl_q;
    assign cnt_o    = cnt_q;
    assign en_o     = en_q;
    assign expire_o = expire;
endmodule

// File: rtl/evtimer_irq.sv
module evtimer_irq #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ien,
    input  logic              wr_ist,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] ien_o,
    output logic [NUM_CH-1:0] ist_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] ien_q, ist_q, clr_bits;

    assign clr_bits = wr_ist ? wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
            ist_q <= '0;
        end else begin
            if (wr_ien) ien_q <= wbits;
            ist_q <= (ist_q & ~clr_bits) | expire;
        end
    end

    assign ien_o = ien_q;
    assign ist_o = ist_q;
    assign irq_o = |(ist_q & ien_q);
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int PRE_W  = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int CSEL_W = ADDR_W - CH_SHIFT;

    logic [ADDR_W-1:0] rel;
    logic [4:0]        sub;
    logic              aligned, in_ch;

    logic [NUM_CH-1:0]             hit_v, exp_v, en_v, ien_v, ist_v;
    logic [NUM_CH-1:0][DATA_W-1:0] ctrl_v;
    logic [NUM_CH-1:0][CNT_W-1:0]  ivl_v, cnt_v;

    assign rel     = bus_addr - ADDR_W'(CH_BASE);
    assign sub     = rel[CH_SHIFT-1:0];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign in_ch   = (bus_addr >= ADDR_W'(CH_BASE));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign hit_v[g] = in_ch && aligned &&
                          (rel[ADDR_W-1:CH_SHIFT] == CSEL_W'(g));

        evtimer_channel #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (bus_we && hit_v[g] && (sub == SUB_CTRL)),
            .wr_ivl_lo(bus_we && hit_v[g] && (sub == SUB_IVL_LO)),
            .wr_ivl_hi(bus_we && hit_v[g] && (sub == SUB_IVL_HI)),
            .wdata    (bus_wdata),
            .ctrl_o   (ctrl_v[g]),
            .ivl_o    (ivl_v[g]),
            .cnt_o    (cnt_v[g]),
            .en_o     (en_v[g]),
            .expire_o (exp_v[g])
        );
    end

    evtimer_irq #(.NUM_CH(NUM_CH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ien(bus_we && (bus_addr == ADDR_W'(OFF_IEN))),
        .wr_ist(bus_we && (bus_addr == ADDR_W'(OFF_IST))),
        .wbits (bus_wdata[NUM_CH-1:0]),
        .expire(exp_v),
        .ien_o (ien_v),
        .ist_o (ist_v),
        .irq_o (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IEN))      bus_rdata[NUM_CH-1:0] = ien_v;
        else if (bus_addr == ADDR_W'(OFF_IST)) bus_rdata[NUM_CH-1:0] = ist_v;
        for (int i = 0; i < NUM_CH; i++) begin
            if (hit_v[i]) begin
                case (sub)
                    SUB_CTRL:   bus_rdata = ctrl_v[i];
                    SUB_IVL_LO: bus_rdata = ivl_v[i][DATA_W-1:0];
                    SUB_IVL_HI: bus_rdata = ivl_v[i][CNT_W-1:DATA_W];
                    SUB_CNT_LO: bus_rdata = cnt_v[i][DATA_W-1:0];
                    SUB_CNT_HI: bus_rdata = cnt_v[i][CNT_W-1:DATA_W];
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64,
    parameter int ADDR_W = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           bus_we,
    input logic [DATA_W-1:0]              bus_rdata,
    input logic                           irq_o,
    input logic [NUM_CH-1:0]              exp_v,
    input logic [NUM_CH-1:0]              en_v,
    input logic [NUM_CH-1:0]              ist_v,
    input logic [NUM_CH-1:0][CNT_W-1:0]   cnt_v
);
    // R2
    unaligned_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

    // R12
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(|exp_v) || $past(bus_we)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R7
        expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            exp_v[g] |-> (cnt_v[g] == '0));

        // R7
        status_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ist_v[g]) |-> $past(exp_v[g]));

        // R11
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            exp_v[g] |=> ist_v[g]);

        // R10
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_v[g] && !bus_we) |=> $stable(cnt_v[g]));
    end
endmodule

bind evtimer_top evtimer_chk #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .CNT_W (2 * DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .exp_v    (exp_v),
    .en_v     (en_v),
    .ist_v    (ist_v),
    .cnt_v    (cnt_v)
);

// File: tb/evtimer_top_tb.sv
`timescale 1ns/1ps
module evtimer_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    evtimer_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    localparam logic [7:0] A_IEN = 8'h00;
    localparam logic [7:0] A_IST = 8'h04;
    function automatic logic [7:0] a_ctrl(int n);   return 8'(32*n + 'h10); endfunction
    function automatic logic [7:0] a_ivlo(int n);   return 8'(32*n + 'h14); endfunction
    function automatic logic [7:0] a_ivhi(int n);   return 8'(32*n + 'h18); endfunction
    function automatic logic [7:0] a_cnlo(int n);   return 8'(32*n + 'h1C); endfunction
    function automatic logic [7:0] a_cnhi(int n);   return 8'(32*n + 'h20); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write commits at the edge after the starting negedge
    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_IEN, v);      check("R1 ien", v, 0);
        rd(A_IST, v);      check("R1 status", v, 0);
        rd(a_ctrl(0), v);  check("R1 ctrl", v, 0);
        rd(a_cnlo(0), v);  check("R1 count", v, 0);
        check("R1 irq", 32'(irq_o), 0);
    endtask

    task automatic t_map_load();
        logic [31:0] v;
        wr(a_ivlo(0), 10);
        wr(a_ivhi(0), 0);
        wr(a_ctrl(0), 32'hF2);
        rd(a_ctrl(0), v);  check("R3 ctrl readback", v, 32'hF0);
        rd(a_cnlo(0), v);  check("R4 reload without enable", v, 10);
        wr(a_ctrl(0), 32'h02);
        rd(a_ivlo(0), v);  check("R2 interval readback", v, 10);
        wr(a_ivlo(3), 5);
        wr(a_ivhi(3), 1);
        wr(a_ctrl(3), 32'h02);
        rd(a_cnhi(3), v);  check("R4 high word", v, 1);
        rd(a_cnlo(3), v);  check("R4 low word", v, 5);
        rd(8'h08, v);      check("R2 unmapped", v, 0);
        rd(8'h0E, v);      check("R2 unaligned", v, 0);
        rd(8'hF0, v);      check("R2 beyond channels", v, 0);
        wr(a_cnlo(3), 32'h55);
        rd(a_cnlo(3), v);  check("R2 count write ignored", v, 5);
    endtask

    task automatic t_countdown();
        logic [31:0] v;
        wr(a_ctrl(0), 32'h01);
        rd(a_cnlo(0), v);  check("R5 first decrement", v, 9);
        rd(a_cnlo(0), v);  check("R5 second decrement", v, 8);
        wr(a_ctrl(0), 32'h00);
        repeat (4) @(negedge clk);
        rd(a_cnlo(0), v);  check("R10 frozen after disable", v, 7);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(a_ivlo(1), 100);
        wr(a_ctrl(1), 32'h02);
        wr(a_ctrl(1), 32'h21);
        repeat (9) @(negedge clk);
        rd(a_cnlo(1), v);  check("R6 divide by four", v, 98);
        wr(a_ctrl(1), 32'h00);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(a_ivlo(0), 3);
        wr(A_IEN, 1);
        wr(a_ctrl(0), 32'h03);
        repeat (3) @(negedge clk);
        check("R7 no irq before expiry", 32'(irq_o), 0);
        @(negedge clk);
        check("R12 irq on expiry", 32'(irq_o), 1);
        rd(A_IST, v);      check("R7 status set", v, 1);
        rd(a_cnlo(0), v);  check("R8 periodic reload", v, 1);
        wr(a_ctrl(0), 32'h00);
        wr(A_IST, 1);
        rd(A_IST, v);      check("R11 clear", v, 0);
        check("R12 irq dropped", 32'(irq_o), 0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr(a_ctrl(0), 32'h03);
        repeat (2) @(negedge clk);
        wr(A_IST, 1);
        rd(A_IST, v);      check("R11 set wins over clear", v, 1);
        wr(a_ctrl(0), 32'h00);
        wr(A_IST, 0);
        rd(A_IST, v);      check("R11 write zero ignored", v, 1);
        wr(A_IST, 1);
        rd(A_IST, v);      check("R11 plain clear", v, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        wr(A_IEN, 0);
        wr(a_ivlo(0), 2);
        wr(a_ctrl(0), 32'h83);
        repeat (5) @(negedge clk);
        check("R12 masked irq", 32'(irq_o), 0);
        rd(A_IST, v);      check("R9 one-shot expiry", v, 1);
        wr(A_IST, 1);
        repeat (10) @(negedge clk);
        rd(A_IST, v);      check("R9 no second expiry", v, 0);
        rd(a_cnlo(0), v);  check("R9 counter held at zero", v, 0);
        rd(a_ctrl(0), v);  check("R3 one-shot ctrl", v, 32'h81);
        wr(a_ctrl(0), 32'h83);
        repeat (5) @(negedge clk);
        wr(A_IEN, 1);
        check("R12 unmask raises irq", 32'(irq_o), 1);
        wr(A_IST, 1);
        wr(a_ctrl(0), 32'h00);
        wr(A_IEN, 0);
    endtask

    task automatic t_freerun();
        logic [31:0] v;
        wr(a_ivlo(2), 32'hFFFF_FFFF);
        wr(a_ivhi(2), 32'hFFFF_FFFF);
        wr(a_ctrl(2), 32'h03);
        rd(a_cnlo(2), v);  check("R13 inverted count one", ~v, 1);
        rd(a_cnlo(2), v);  check("R13 inverted count two", ~v, 2);
        rd(a_cnhi(2), v);  check("R13 high word", v, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map_load();
        t_countdown();
        t_prescale();
        t_periodic();
        t_collision();
        t_oneshot();
        t_freerun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule